// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block is the control face of a TPM 2.0 command-response buffer interface. Software reaches it as a memory-mapped slave. Through it, software claims and releases locality ownership, moves the TPM between idle and ready, starts a command that already sits in the shared buffer, and asks for that command to be cancelled. It also reads constant identification and buffer-descriptor words.

Behind the register block sits a command-processing backend. When software starts a command, the block sends the backend a one-cycle request pulse. The pulse carries the command length, which is the size from the command header clamped to the buffer space that can actually be used. The backend answers with a one-cycle done pulse and a status word. The done pulse clears the start flag. A nonzero status leaves a fatal-error flag set.

The upper address bits above bit 11 name the locality of an access, so each locality has its own 4 KiB window. The registers are shared by all windows. Only the start register looks at which locality wrote it.

Top module: `cmdrsp_ctrl`

## Requirements
- R1: After reset, the registers read as follows:
  - locality state (offset 0x000): 0x80, with bit 7 = registers valid, bit 1 = owned, bits 4:2 = active locality 0.
  - locality status (0x00C): 0, with bit 0 = granted and bit 1 = seized.
  - control status (0x044): 0x2, with bit 1 = idle and bit 0 = fatal.
  - start (0x04C): 0, with bit 0 = busy.
  - identification (0x030): 0x6C11. The fields are kind 1 in bits 3:0, version 1 in bits 7:4, transfer size code 3 in bits 11:10, buffer-mode capable in bit 13, and selector 1 in bits 15:14. Every other field is 0.
  - command size and response size (0x058 and 0x064): the usable buffer byte count.
  - command address and response address (0x05C and 0x068): the buffer base.
- R2: Writing exactly 0x1 to locality control (0x008) sets owned and granted and clears seized.
- R3: Writing exactly 0x2 to locality control clears owned and granted. Any other value, including 0x8, changes nothing.
- R4: Writing exactly 0x1 to control request (0x040) clears idle. Writing exactly 0x2 sets idle. Any other value has no effect.
- R5: Writing 0x1 to start (0x04C) is accepted only when busy is clear, owned is set, and the writer's locality (address bits above 11) equals the active locality 0. An accepted write sets busy and gives exactly one be_req pulse in the next cycle.
- R6: A start write while busy is set produces no request.
- R7: be_in_len is the smaller of cmd_hdr_len and the usable buffer size, which is the lesser of BUF_BYTES and BE_BUF_BYTES.
- R8: Writing 0x1 to cancel (0x048) pulses be_cancel in the next cycle only while busy is set. Otherwise the write is ignored.
- R9: be_done clears busy. be_done with a nonzero be_status sets the fatal bit, which stays set until reset.
- R10: A read returns the addressed word shifted right by 8 times the low two address bits, then masked to bus_size+1 bytes. The result appears one cycle later with bus_rvalid.
- R11: A read whose low 12 address bits are all zero ORs bit 0 of the result with the inverse of be_est. A read at any other byte of that word does not.
- R12: A write value is masked to bus_size+1 bytes before it is compared. A write at an address that is not word aligned matches no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits above 11 give the locality |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_size | input | 2 | Access width minus one, in bytes |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_rdata | output | 32 | Read data |
| be_req | output | 1 | One-cycle command request to the backend |
| be_in_len | output | 32 | Command length sent with be_req |
| be_cancel | output | 1 | One-cycle cancel request to the backend |
| be_done | input | 1 | Backend completion pulse |
| be_status | input | 32 | Completion status; nonzero means failure |
| be_est | input | 1 | Backend established flag |
| cmd_hdr_len | input | 32 | Size field read from the command header |

## Verification
The hardest state to reach is the window in which a command is in flight. Cancel is live only inside this window, and a second start must be refused there. To get into the window, the bench first claims ownership from locality 0. It then starts a command and holds the backend stub's done pulse back for a chosen number of idle cycles. During that hold it issues a second start, a cancel, and status reads. A start from another locality's window, and a start made without ownership, are used to show that the ownership and locality checks each block the request on their own. The bench also sends header lengths on both sides of the usable size, so that both arms of the length clamp are exercised.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

    localparam int DATA_W = 32;

    // Word offsets inside each 4 KiB locality window
    localparam logic [11:0] OFF_LOC_STATE = 12'h000;
    localparam logic [11:0] OFF_LOC_CTRL  = 12'h008;
    localparam logic [11:0] OFF_LOC_STS   = 12'h00C;
    localparam logic [11:0] OFF_INTF_ID   = 12'h030;
    localparam logic [11:0] OFF_CTRL_REQ  = 12'h040;
    localparam logic [11:0] OFF_CTRL_STS  = 12'h044;
    localparam logic [11:0] OFF_CANCEL    = 12'h048;
    localparam logic [11:0] OFF_START     = 12'h04C;
    localparam logic [11:0] OFF_CMD_SIZE  = 12'h058;
    localparam logic [11:0] OFF_CMD_ADDR  = 12'h05C;
    localparam logic [11:0] OFF_RSP_SIZE  = 12'h064;
    localparam logic [11:0] OFF_RSP_ADDR  = 12'h068;

    // Exact command codes
    localparam logic [DATA_W-1:0] LC_CLAIM   = 32'h1;
    localparam logic [DATA_W-1:0] LC_RELEASE = 32'h2;
    localparam logic [DATA_W-1:0] RQ_READY   = 32'h1;
    localparam logic [DATA_W-1:0] RQ_IDLE    = 32'h2;
    localparam logic [DATA_W-1:0] CODE_GO    = 32'h1;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_LOC_STATE,
        RG_LOC_CTRL,
        RG_LOC_STS,
        RG_INTF_ID,
        RG_CTRL_REQ,
        RG_CTRL_STS,
        RG_CANCEL,
        RG_START,
        RG_CMD_SIZE,
        RG_CMD_ADDR,
        RG_RSP_SIZE,
        RG_RSP_ADDR
    } reg_sel_e;

    typedef struct packed {
        logic [11:0] rsvd;
        logic [3:0]  rev;
        logic [1:0]  selector;
        logic        buf_mode_cap;
        logic        fifo_cap;
        logic [1:0]  xfer_cap;
        logic        fast_idle;
        logic        multi_loc;
        logic [3:0]  version;
        logic [3:0]  kind;
    } intf_id_t;

    typedef struct packed {
        logic [23:0] rsvd;
        logic        regs_valid;
        logic [1:0]  rsvd_lo;
        logic [2:0]  active;
        logic        owned;
        logic        est_n;
    } loc_state_t;

    function automatic reg_sel_e reg_decode(input logic [11:0] off);
        case ({off[11:2], 2'b00})
            OFF_LOC_STATE: return RG_LOC_STATE;
            OFF_LOC_CTRL:  return RG_LOC_CTRL;
            OFF_LOC_STS:   return RG_LOC_STS;
            OFF_INTF_ID:   return RG_INTF_ID;
            OFF_CTRL_REQ:  return RG_CTRL_REQ;
            OFF_CTRL_STS:  return RG_CTRL_STS;
            OFF_CANCEL:    return RG_CANCEL;
            OFF_START:     return RG_START;
            OFF_CMD_SIZE:  return RG_CMD_SIZE;
            OFF_CMD_ADDR:  return RG_CMD_ADDR;
            OFF_RSP_SIZE:  return RG_RSP_SIZE;
            OFF_RSP_ADDR:  return RG_RSP_ADDR;
            default:       return RG_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            2'd2:    return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] intf_id_word();
        intf_id_t id;
        id              = '0;
        id.kind         = 4'h1;
        id.version      = 4'h1;
        id.multi_loc    = 1'b0;
        id.fast_idle    = 1'b0;
        id.xfer_cap     = 2'b11;
        id.fifo_cap     = 1'b0;
        id.buf_mode_cap = 1'b1;
        id.selector     = 2'b01;
        id.rev          = 4'h0;
        return id;
    endfunction

    function automatic logic [DATA_W-1:0] loc_state_word(input logic owned);
        loc_state_t ls;
        ls            = '0;
        ls.regs_valid = 1'b1;
        ls.active     = 3'd0;
        ls.owned      = owned;
        return ls;
    endfunction

endpackage

// File: rtl/cmdrsp_bus_dec.sv
module cmdrsp_bus_dec
    import cmdrsp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_size,
    output reg_sel_e          wr_sel,
    output logic [DATA_W-1:0] wr_val,
    output logic [ADDR_W-13:0] wr_loc,
    output logic              rd_en,
    output reg_sel_e          rd_sel,
    output logic [1:0]        rd_shift,
    output logic [DATA_W-1:0] rd_mask,
    output logic              rd_exact0
);
    logic [11:0] off;
    reg_sel_e    word_sel;

    assign off      = bus_addr[11:0];
    assign word_sel = reg_decode(off);
    assign rd_mask  = size_mask(bus_size);

    always_comb begin
        // Only word-aligned writes can hit a register
        wr_sel    = (bus_valid && bus_write && off[1:0] == 2'b00) ? word_sel : RG_NONE;
        wr_val    = bus_wdata & rd_mask;
        wr_loc    = bus_addr[ADDR_W-1:12];
        rd_en     = bus_valid && !bus_write;
        rd_sel    = word_sel;
        rd_shift  = off[1:0];
        rd_exact0 = (off == OFF_LOC_STATE);
    end
endmodule

// File: rtl/cmdrsp_loc_arb.sv
module cmdrsp_loc_arb
    import cmdrsp_pkg::*;
#(
    parameter int LOC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    output logic              owned,
    output logic              granted,
    output logic              seized,
    output logic [LOC_W-1:0]  act_loc
);
    // Only locality 0 can ever become active
    assign act_loc = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            owned   <= 1'b0;
            granted <= 1'b0;
            seized  <= 1'b0;
        end else if (wr_sel == RG_LOC_CTRL) begin
            if (wr_val == LC_CLAIM) begin
                owned   <= 1'b1;
                granted <= 1'b1;
                seized  <= 1'b0;
            end else if (wr_val == LC_RELEASE) begin
                owned   <= 1'b0;
                granted <= 1'b0;
            end
        end
    end

    p_claim_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == RG_LOC_CTRL && wr_val == LC_CLAIM) |=> (owned && granted && !seized));

    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == RG_LOC_CTRL && wr_val == LC_RELEASE) |=> (!owned && !granted));

    p_other_code_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == RG_LOC_CTRL && wr_val != LC_CLAIM && wr_val != LC_RELEASE)
        |=> ($stable(owned) && $stable(granted)));
endmodule

// File: rtl/cmdrsp_cmd_ctl.sv
module cmdrsp_cmd_ctl
    import cmdrsp_pkg::*;
#(
    parameter int BUF_BYTES    = 3968,
    parameter int BE_BUF_BYTES = 4096,
    parameter int LOC_W        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [LOC_W-1:0]  wr_loc,
    input  logic              owned,
    input  logic [LOC_W-1:0]  act_loc,
    input  logic [DATA_W-1:0] hdr_len,
    input  logic              be_done,
    input  logic [DATA_W-1:0] be_status,
    output logic              idle,
    output logic              fatal,
    output logic              start,
    output logic              be_req,
    output logic [DATA_W-1:0] be_in_len,
    output logic              be_cancel
);
    localparam int USABLE = (BE_BUF_BYTES < BUF_BYTES) ? BE_BUF_BYTES : BUF_BYTES;
    localparam logic [DATA_W-1:0] USABLE_W = DATA_W'(USABLE);

    logic              accept;
    logic              cancel_hit;
    logic [DATA_W-1:0] clamp_len;

    always_comb begin
        accept     = (wr_sel == RG_START) && (wr_val == CODE_GO) && !start
                     && owned && (wr_loc == act_loc);
        cancel_hit = (wr_sel == RG_CANCEL) && (wr_val == CODE_GO) && start;
        clamp_len  = (hdr_len < USABLE_W) ? hdr_len : USABLE_W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle      <= 1'b1;
            fatal     <= 1'b0;
            start     <= 1'b0;
            be_req    <= 1'b0;
            be_in_len <= '0;
            be_cancel <= 1'b0;
        end else begin
            if (wr_sel == RG_CTRL_REQ) begin
                if (wr_val == RQ_READY)     idle <= 1'b0;
                else if (wr_val == RQ_IDLE) idle <= 1'b1;
            end
            if (accept)       start <= 1'b1;
            else if (be_done) start <= 1'b0;
            if (be_done && be_status != '0) fatal <= 1'b1;
            be_req    <= accept;
            be_cancel <= cancel_hit;
            if (accept) be_in_len <= clamp_len;
        end
    end

    p_ready_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == RG_CTRL_REQ && wr_val == RQ_READY) |=> !idle);

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        be_req |=> !be_req);

    p_req_busy_r5: assert property (@(posedge clk) disable iff (rst)
        be_req |-> start);

    p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !be_done) |=> !be_req);

    p_len_cap_r7: assert property (@(posedge clk) disable iff (rst)
        be_req |-> (be_in_len <= USABLE_W));

    p_cancel_busy_r8: assert property (@(posedge clk) disable iff (rst)
        be_cancel |-> $past(start));

    p_done_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (be_done && wr_sel != RG_START) |=> !start);

    p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        fatal |=> fatal);
endmodule

// File: rtl/cmdrsp_rd_mux.sv
module cmdrsp_rd_mux
    import cmdrsp_pkg::*;
#(
    parameter int                BUF_SIZE = 3968,
    parameter logic [DATA_W-1:0] BUF_BASE = 32'hFED4_0080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_sel_e          rd_sel,
    input  logic [1:0]        rd_shift,
    input  logic [DATA_W-1:0] rd_mask,
    input  logic              rd_exact0,
    input  logic              owned,
    input  logic              granted,
    input  logic              seized,
    input  logic              idle,
    input  logic              fatal,
    input  logic              start,
    input  logic              be_est,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [DATA_W-1:0] BUF_SIZE_W = DATA_W'(BUF_SIZE);

    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] merged;

    always_comb begin
        case (rd_sel)
            RG_LOC_STATE: word = loc_state_word(owned);
            RG_LOC_STS:   word = {30'b0, seized, granted};
            RG_INTF_ID:   word = intf_id_word();
            RG_CTRL_STS:  word = {30'b0, idle, fatal};
            RG_START:     word = {31'b0, start};
            RG_CMD_SIZE,
            RG_RSP_SIZE:  word = BUF_SIZE_W;
            RG_CMD_ADDR,
            RG_RSP_ADDR:  word = BUF_BASE;
            default:      word = '0;
        endcase
        shifted = word >> {rd_shift, 3'b000};
        merged  = shifted;
        if (rd_exact0) merged[0] = shifted[0] | !be_est;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= merged & rd_mask;
        end
    end

    p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> bus_rvalid);

    p_byte_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_mask == 32'h0000_00FF) |=> (bus_rdata[31:8] == 24'h0));
endmodule

// File: rtl/cmdrsp_ctrl.sv
module cmdrsp_ctrl
    import cmdrsp_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          BUF_BYTES    = 3968,
    parameter int          BE_BUF_BYTES = 4096,
    parameter logic [31:0] BUF_BASE     = 32'hFED4_0080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [1:0]        bus_size,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              be_req,
    output logic [31:0]       be_in_len,
    output logic              be_cancel,
    input  logic              be_done,
    input  logic [31:0]       be_status,
    input  logic              be_est,
    input  logic [31:0]       cmd_hdr_len
);
    localparam int LOC_W  = ADDR_W - 12;
    localparam int USABLE = (BE_BUF_BYTES < BUF_BYTES) ? BE_BUF_BYTES : BUF_BYTES;

    reg_sel_e          wr_sel;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] wr_val;
    logic [LOC_W-1:0]  wr_loc;
    logic [LOC_W-1:0]  act_loc;
    logic              rd_en;
    logic [1:0]        rd_shift;
    logic [DATA_W-1:0] rd_mask;
    logic              rd_exact0;
    logic              owned, granted, seized;
    logic              idle, fatal, start;

    cmdrsp_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_size  (bus_size),
        .wr_sel    (wr_sel),
        .wr_val    (wr_val),
        .wr_loc    (wr_loc),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .rd_shift  (rd_shift),
        .rd_mask   (rd_mask),
        .rd_exact0 (rd_exact0)
    );

    cmdrsp_loc_arb #(.LOC_W(LOC_W)) u_loc (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (wr_sel),
        .wr_val  (wr_val),
        .owned   (owned),
        .granted (granted),
        .seized  (seized),
        .act_loc (act_loc)
    );

    cmdrsp_cmd_ctl #(
        .BUF_BYTES    (BUF_BYTES),
        .BE_BUF_BYTES (BE_BUF_BYTES),
        .LOC_W        (LOC_W)
    ) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_sel    (wr_sel),
        .wr_val    (wr_val),
        .wr_loc    (wr_loc),
        .owned     (owned),
        .act_loc   (act_loc),
        .hdr_len   (cmd_hdr_len),
        .be_done   (be_done),
        .be_status (be_status),
        .idle      (idle),
        .fatal     (fatal),
        .start     (start),
        .be_req    (be_req),
        .be_in_len (be_in_len),
        .be_cancel (be_cancel)
    );

    cmdrsp_rd_mux #(
        .BUF_SIZE (USABLE),
        .BUF_BASE (BUF_BASE)
    ) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .rd_sel     (rd_sel),
        .rd_shift   (rd_shift),
        .rd_mask    (rd_mask),
        .rd_exact0  (rd_exact0),
        .owned      (owned),
        .granted    (granted),
        .seized     (seized),
        .idle       (idle),
        .fatal      (fatal),
        .start      (start),
        .be_est     (be_est),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata)
    );

    // Request and cancel never share a cycle with a fresh start of the same command
    p_req_cancel_excl_r8: assert property (@(posedge clk) disable iff (rst)
        be_req |-> !be_cancel);
endmodule

// File: tb/cmdrsp_ctrl_bench.sv
`timescale 1ns/1ps
module cmdrsp_ctrl_bench;
    localparam int          ADDR_W = 16;
    localparam int          BUFB   = 3968;
    localparam int          BEBUF  = 4096;
    localparam logic [31:0] BASE   = 32'hFED4_0080;
    localparam logic [31:0] USE_SZ = 32'd3968;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = 2'd3;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        be_req, be_cancel;
    logic [31:0] be_in_len;
    logic        be_done = 1'b0;
    logic [31:0] be_status = '0;
    logic        be_est = 1'b1;
    logic [31:0] cmd_hdr_len = 32'd10;

    always #2.5 clk = ~clk;

    cmdrsp_ctrl #(
        .ADDR_W(ADDR_W), .BUF_BYTES(BUFB), .BE_BUF_BYTES(BEBUF), .BUF_BASE(BASE)
    ) u_cmdrsp_ctrl (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .be_req(be_req),
        .be_in_len(be_in_len), .be_cancel(be_cancel), .be_done(be_done),
        .be_status(be_status), .be_est(be_est), .cmd_hdr_len(cmd_hdr_len)
    );

    // Behavioural reference state
    bit          m_owned = 0, m_granted = 0, m_idle = 1, m_start = 0, m_fatal = 0;
    logic        e_req = 0, e_cancel = 0, e_rvalid = 0;
    logic [31:0] e_rdata = '0, e_len = '0;
    string       cur_tag = "R1";
    int          checks = 0, errors = 0;
    bit          finished = 0;

    function automatic logic [31:0] mdl_mask(input logic [1:0] sz);
        return (sz == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (sz + 1))) - 1);
    endfunction

    function automatic logic [31:0] mdl_word(input logic [11:0] w);
        case (w)
            12'h000: return 32'h80 | (32'(m_owned) << 1);
            12'h00C: return 32'(m_granted);
            12'h030: return 32'h0000_6C11;
            12'h044: return (32'(m_idle) << 1) | 32'(m_fatal);
            12'h04C: return 32'(m_start);
            12'h058, 12'h064: return USE_SZ;
            12'h05C, 12'h068: return BASE;
            default: return 32'h0;
        endcase
    endfunction

    task automatic step(input logic v, input logic w, input logic [15:0] a,
                        input logic [31:0] d, input logic [1:0] sz,
                        input logic dn, input logic [31:0] st);
        logic [31:0] tmp, val;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; bus_size = sz;
        be_done = dn; be_status = st;
        e_req = 0; e_cancel = 0; e_rvalid = 0;
        if (v && !w) begin
            e_rvalid = 1;
            tmp = mdl_word({a[11:2], 2'b00}) >> (8 * a[1:0]);
            if (a[11:0] == 12'h000) tmp[0] = tmp[0] | !be_est;
            e_rdata = tmp & mdl_mask(sz);
        end
        if (v && w && a[1:0] == 2'b00) begin
            val = d & mdl_mask(sz);
            case (a[11:0])
                12'h008: if (val == 1) begin m_owned = 1; m_granted = 1; end
                         else if (val == 2) begin m_owned = 0; m_granted = 0; end
                12'h040: if (val == 1) m_idle = 0; else if (val == 2) m_idle = 1;
                12'h048: if (val == 1 && m_start) e_cancel = 1;
                12'h04C: if (val == 1 && !m_start && m_owned && a[15:12] == 4'd0) begin
                    m_start = 1; e_req = 1;
                    e_len = (cmd_hdr_len < USE_SZ) ? cmd_hdr_len : USE_SZ;
                end
                default: ;
            endcase
        end
        if (dn) begin
            m_start = 0;
            if (st != 0) m_fatal = 1;
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd3);
        step(1, 1, a, d, sz, 0, 0);
    endtask
    task automatic rd(input logic [15:0] a, input logic [1:0] sz = 2'd3);
        step(1, 0, a, 0, sz, 0, 0);
    endtask
    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 3, 0, 0);
    endtask
    // Backend stub: completes after a programmable number of cycles
    task automatic backend_finish(input int lat, input logic [31:0] st);
        idle_n(lat);
        step(0, 0, 0, 0, 3, 1, st);
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", cur_tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            chk("be_req", 32'(be_req), 32'(e_req));
            chk("be_cancel", 32'(be_cancel), 32'(e_cancel));
            chk("bus_rvalid", 32'(bus_rvalid), 32'(e_rvalid));
            if (e_rvalid) chk("bus_rdata", bus_rdata, e_rdata);
            if (e_req) chk("be_in_len", be_in_len, e_len);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        cur_tag = "R1";
        rd(16'h0000); rd(16'h000C); rd(16'h0044); rd(16'h004C); rd(16'h0030);
        rd(16'h0058); rd(16'h005C); rd(16'h0064); rd(16'h0068);
        // R11 established flag at exact offset only
        cur_tag = "R11";
        be_est = 0; rd(16'h0000); rd(16'h0000, 2'd0); rd(16'h0001, 2'd0); rd(16'h1000);
        be_est = 1; rd(16'h0000);
        // R3 ignored codes
        cur_tag = "R3";
        wr(16'h0008, 32'h8); rd(16'h0000); rd(16'h000C);
        wr(16'h0008, 32'h3); rd(16'h0000);
        // R2 claim
        cur_tag = "R2";
        wr(16'h0008, 32'h1); rd(16'h0000); rd(16'h000C);
        // R3 release
        cur_tag = "R3";
        wr(16'h0008, 32'h2); rd(16'h0000); rd(16'h000C);
        // R4 idle handshake
        cur_tag = "R4";
        wr(16'h0040, 32'h1); rd(16'h0044);
        wr(16'h0040, 32'h3); rd(16'h0044);
        wr(16'h0040, 32'h2); rd(16'h0044);
        wr(16'h0040, 32'h1); rd(16'h0044);
        // R5 start refused without ownership, and from another locality
        cur_tag = "R5";
        wr(16'h004C, 32'h1); idle_n(2); rd(16'h004C);
        wr(16'h0008, 32'h1);
        wr(16'h104C, 32'h1); idle_n(2); rd(16'h004C);
        wr(16'h004C, 32'h2); idle_n(1); rd(16'h004C);
        // R5/R7 accepted start, short header
        cur_tag = "R7";
        cmd_hdr_len = 32'd10;
        wr(16'h004C, 32'h1); rd(16'h004C);
        // R6 second start while busy
        cur_tag = "R6";
        wr(16'h004C, 32'h1); idle_n(1);
        // R8 cancel while busy
        cur_tag = "R8";
        wr(16'h0048, 32'h1); idle_n(1);
        // R9 successful completion
        cur_tag = "R9";
        backend_finish(4, 32'h0); rd(16'h004C); rd(16'h0044);
        // R8 cancel when not busy ignored
        cur_tag = "R8";
        wr(16'h0048, 32'h1); idle_n(1); wr(16'h0048, 32'h0); idle_n(1);
        // R7 long header clamps
        cur_tag = "R7";
        cmd_hdr_len = 32'd5000;
        wr(16'h004C, 32'h1); idle_n(1);
        cur_tag = "R9";
        backend_finish(7, 32'h5); rd(16'h004C); rd(16'h0044);
        wr(16'h0040, 32'h2); rd(16'h0044);
        // R5 start after completion from locality 0 again, header exactly usable size
        cur_tag = "R5";
        cmd_hdr_len = USE_SZ;
        wr(16'h004C, 32'h1); idle_n(1);
        backend_finish(2, 32'h0); rd(16'h0044);
        // R10 byte-granular reads
        cur_tag = "R10";
        rd(16'h0031, 2'd0); rd(16'h0030, 2'd1); rd(16'h0032, 2'd3);
        rd(16'h005F, 2'd0); rd(16'h005D, 2'd1); rd(16'h2058, 2'd2);
        // R12 masking and alignment of writes
        cur_tag = "R12";
        wr(16'h0040, 32'h101, 2'd0); rd(16'h0044);
        wr(16'h0041, 32'h2, 2'd0); rd(16'h0044);
        wr(16'h0040, 32'h102, 2'd3); rd(16'h0044);
        wr(16'h0040, 32'hFF02, 2'd0); rd(16'h0044);
        wr(16'h0009, 32'h2, 2'd0); rd(16'h0000);
        idle_n(2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule